// File: doc/BRIEF.md
# Dual PLL Clock Source Switcher

This block owns the choice between a digital PLL and an analog PLL as the origin of a shared 48 MHz clock. Out of reset the digital PLL runs and is selected. A software command asks for the other source; the block then walks a strict handshake. It switches the running PLL off and waits for that PLL's lock to disappear. Only then does it enable the other PLL and steer the select line to it. The switch is finished once that PLL reports lock. The same walk, with the two roles exchanged, brings the clock back to the digital PLL.

Each waiting step is guarded by a cycle limit. If a PLL never releases or never acquires lock, the block records a sticky error and falls back to running the source it started from. A separate request bit from the clock consumer decides whether the consumer's clock is enabled. The enable is granted only while the selected PLL is locked and no handover is in flight.

Top module: `pll_src_switch`

## Requirements
- R1: After reset, dig_en=1, ana_en=0, src_sel=0 (0 = digital output selected), and busy, done and err are 0.
- R2: While the digital source runs idle, a sw_req pulse with sw_to_ana=1 makes the next cycle show dig_en=0, ana_en=0, src_sel=0 and busy=1.
- R3: During the release step, the new PLL stays disabled for as long as the old PLL's lock reads 1. The first clock edge that samples the old lock at 0 leads, in the next cycle, to the new PLL being enabled and src_sel pointing at it.
- R4: During the acquire step, the first edge that samples the new PLL's lock at 1 ends the switch. In the next cycle busy=0 and done=1, and done lasts exactly one cycle.
- R5: dig_en and ana_en are never 1 in the same cycle.
- R6: A sw_req pulse while busy=1 has no effect. A sw_req whose sw_to_ana names the source already selected also has no effect.
- R7: From the analog source, sw_req with sw_to_ana=0 runs the same sequence with the roles of the two PLLs exchanged, ending with dig_en=1 and src_sel=0.
- R8: If a release or acquire step lasts WAIT_LIMIT cycles without its exit condition, the next cycle has busy=0 and err=1, with the starting source enabled and selected again. done stays 0.
- R9: Once set, err stays 1 until reset, including across later successful switches.
- R10: clk_en = clk_req AND NOT busy AND (the lock of the selected PLL), evaluated in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_req | input | 1 | One-cycle switch command |
| sw_to_ana | input | 1 | Switch target: 1 analog, 0 digital |
| dig_lock | input | 1 | Digital PLL lock indication |
| ana_lock | input | 1 | Analog PLL global lock indication |
| clk_req | input | 1 | Consumer clock request bit |
| dig_en | output | 1 | Digital PLL enable |
| ana_en | output | 1 | Analog PLL enable |
| src_sel | output | 1 | Clock select: 0 digital, 1 analog |
| clk_en | output | 1 | Consumer clock enable |
| busy | output | 1 | Handover in progress |
| done | output | 1 | One-cycle pulse when a handover completes |
| err | output | 1 | Sticky wait-limit error |

## Verification
The sequencer state appears directly on the enable, select and busy pins, so a wrong state shows up at the ports one cycle after the edge that caused it. A bad direction bit enables or selects the wrong PLL, and a stuck state keeps busy high. A wait counter that runs off by one shifts the fall back to the home source by a single cycle. The bench therefore compares every output against its reference on every cycle, including the exact cycle in which a timeout lands.

// File: rtl/pll_sw_pkg.sv
package pll_sw_pkg;

    typedef enum logic [1:0] {
        ST_DIG_RUN = 2'd0,
        ST_ANA_RUN = 2'd1,
        ST_RELEASE = 2'd2,
        ST_ACQUIRE = 2'd3
    } sw_state_e;

    typedef struct packed {
        sw_state_e state;
        logic      to_ana;
        logic      err;
        logic      done;
    } sw_regs_t;

    localparam sw_regs_t SW_REGS_RESET = '{
        state:  ST_DIG_RUN,
        to_ana: 1'b0,
        err:    1'b0,
        done:   1'b0
    };

endpackage

// File: rtl/pll_sw_timer.sv
module pll_sw_timer #(
    parameter int unsigned WAIT_LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expired
);
    localparam int unsigned CNT_W = $clog2(WAIT_LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_LIMIT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart || !run) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = run && (cnt_q == LAST);

endmodule

// File: rtl/pll_sw_fsm.sv
module pll_sw_fsm
    import pll_sw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sw_req,
    input  logic      sw_to_ana,
    input  logic      dig_lock,
    input  logic      ana_lock,
    input  logic      expired,
    output logic      wait_run,
    output logic      wait_restart,
    output sw_state_e state,
    output logic      to_ana,
    output logic      err,
    output logic      done
);
    sw_regs_t  r_d, r_q;
    logic      old_lock;
    logic      new_lock;
    sw_state_e home_st;
    sw_state_e dest_st;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        wait_run = 1'b0;
        old_lock = r_q.to_ana ? dig_lock : ana_lock;
        new_lock = r_q.to_ana ? ana_lock : dig_lock;
        home_st  = r_q.to_ana ? ST_DIG_RUN : ST_ANA_RUN;
        dest_st  = r_q.to_ana ? ST_ANA_RUN : ST_DIG_RUN;

        unique case (r_q.state)
            ST_DIG_RUN: begin
                if (sw_req && sw_to_ana) begin
                    r_d.state  = ST_RELEASE;
                    r_d.to_ana = 1'b1;
                end
            end
            ST_ANA_RUN: begin
                if (sw_req && !sw_to_ana) begin
                    r_d.state  = ST_RELEASE;
                    r_d.to_ana = 1'b0;
                end
            end
            ST_RELEASE: begin
                wait_run = 1'b1;
                if (!old_lock) begin
                    r_d.state = ST_ACQUIRE;
                end else if (expired) begin
                    r_d.state = home_st;
                    r_d.err   = 1'b1;
                end
            end
            ST_ACQUIRE: begin
                wait_run = 1'b1;
                if (new_lock) begin
                    r_d.state = dest_st;
                    r_d.done  = 1'b1;
                end else if (expired) begin
                    r_d.state = home_st;
                    r_d.err   = 1'b1;
                end
            end
            default: begin
                r_d.state = ST_DIG_RUN;
            end
        endcase

        wait_restart = (r_d.state != r_q.state);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= SW_REGS_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign state  = r_q.state;
    assign to_ana = r_q.to_ana;
    assign err    = r_q.err;
    assign done   = r_q.done;

endmodule

// File: rtl/pll_sw_decode.sv
module pll_sw_decode
    import pll_sw_pkg::*;
(
    input  sw_state_e state,
    input  logic      to_ana,
    input  logic      dig_lock,
    input  logic      ana_lock,
    input  logic      clk_req,
    output logic      dig_en,
    output logic      ana_en,
    output logic      src_sel,
    output logic      busy,
    output logic      clk_en
);
    logic in_release;
    logic in_acquire;
    logic sel_lock;

    always_comb begin
        in_release = (state == ST_RELEASE);
        in_acquire = (state == ST_ACQUIRE);
        busy       = in_release || in_acquire;
        dig_en     = (state == ST_DIG_RUN) || (in_acquire && !to_ana);
        ana_en     = (state == ST_ANA_RUN) || (in_acquire && to_ana);
        src_sel    = (state == ST_ANA_RUN)
                   || (in_release && !to_ana)
                   || (in_acquire && to_ana);
        sel_lock   = src_sel ? ana_lock : dig_lock;
        clk_en     = clk_req && !busy && sel_lock;
    end

endmodule

// File: rtl/pll_src_switch.sv
module pll_src_switch
    import pll_sw_pkg::*;
#(
    parameter int unsigned WAIT_LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_req,
    input  logic sw_to_ana,
    input  logic dig_lock,
    input  logic ana_lock,
    input  logic clk_req,
    output logic dig_en,
    output logic ana_en,
    output logic src_sel,
    output logic clk_en,
    output logic busy,
    output logic done,
    output logic err
);
    logic      wait_run;
    logic      wait_restart;
    logic      expired;
    sw_state_e state;
    logic      to_ana;

    pll_sw_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_req       (sw_req),
        .sw_to_ana    (sw_to_ana),
        .dig_lock     (dig_lock),
        .ana_lock     (ana_lock),
        .expired      (expired),
        .wait_run     (wait_run),
        .wait_restart (wait_restart),
        .state        (state),
        .to_ana       (to_ana),
        .err          (err),
        .done         (done)
    );

    pll_sw_timer #(
        .WAIT_LIMIT (WAIT_LIMIT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (wait_run),
        .restart (wait_restart),
        .expired (expired)
    );

    pll_sw_decode u_dec (
        .state    (state),
        .to_ana   (to_ana),
        .dig_lock (dig_lock),
        .ana_lock (ana_lock),
        .clk_req  (clk_req),
        .dig_en   (dig_en),
        .ana_en   (ana_en),
        .src_sel  (src_sel),
        .busy     (busy),
        .clk_en   (clk_en)
    );

endmodule

// File: rtl/pll_sw_checker.sv
module pll_sw_checker (
    input logic clk,
    input logic rst_n,
    input logic sw_req,
    input logic sw_to_ana,
    input logic dig_lock,
    input logic ana_lock,
    input logic clk_req,
    input logic dig_en,
    input logic ana_en,
    input logic src_sel,
    input logic clk_en,
    input logic busy,
    input logic done,
    input logic err
);
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dig_en && !ana_en && !src_sel && !busy && !err));

    p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(dig_en && ana_en));

    p_release_to_ana_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !dig_en && !ana_en && !src_sel && dig_lock) |=> !ana_en);

    p_release_to_dig_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !dig_en && !ana_en && src_sel && ana_lock) |=> !dig_en);

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_same_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !src_sel && sw_req && !sw_to_ana) |=> !busy);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> (clk_req && !busy));

endmodule

bind pll_src_switch pll_sw_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_req    (sw_req),
    .sw_to_ana (sw_to_ana),
    .dig_lock  (dig_lock),
    .ana_lock  (ana_lock),
    .clk_req   (clk_req),
    .dig_en    (dig_en),
    .ana_en    (ana_en),
    .src_sel   (src_sel),
    .clk_en    (clk_en),
    .busy      (busy),
    .done      (done),
    .err       (err)
);

// File: tb/pll_src_switch_tb.sv
module pll_src_switch_tb_top;
    localparam int LIM = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_req = 1'b0, sw_to_ana = 1'b0;
    logic dig_lock = 1'b0, ana_lock = 1'b0, clk_req = 1'b0;
    logic dig_en, ana_en, src_sel, clk_en, busy, done, err;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    string cur_req = "R1";

    // reference model state: 0 digital idle, 1 analog idle, 2 release, 3 acquire
    int m_st = 0, m_dir = 0, m_cnt = 0, m_err = 0, m_done = 0;

    always #4 clk = ~clk;

    pll_src_switch #(.WAIT_LIMIT(LIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_to_ana(sw_to_ana),
        .dig_lock(dig_lock), .ana_lock(ana_lock), .clk_req(clk_req),
        .dig_en(dig_en), .ana_en(ana_en), .src_sel(src_sel), .clk_en(clk_en),
        .busy(busy), .done(done), .err(err)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int nxt, old_l, new_l, expd;
        if (!rst_n) begin
            m_st = 0; m_dir = 0; m_cnt = 0; m_err = 0; m_done = 0;
        end else begin
            nxt = m_st;
            m_done = 0;
            old_l = m_dir ? int'(dig_lock) : int'(ana_lock);
            new_l = m_dir ? int'(ana_lock) : int'(dig_lock);
            expd = (m_st >= 2) && (m_cnt == LIM - 1);
            if (m_st == 0 && sw_req && sw_to_ana) begin nxt = 2; m_dir = 1; end
            else if (m_st == 1 && sw_req && !sw_to_ana) begin nxt = 2; m_dir = 0; end
            else if (m_st == 2) begin
                if (!old_l) nxt = 3;
                else if (expd) begin nxt = m_dir ? 0 : 1; m_err = 1; end
            end else if (m_st == 3) begin
                if (new_l) begin nxt = m_dir ? 1 : 0; m_done = 1; end
                else if (expd) begin nxt = m_dir ? 0 : 1; m_err = 1; end
            end
            if (nxt != m_st || m_st < 2) m_cnt = 0;
            else m_cnt = m_cnt + 1;
            m_st = nxt;
        end
    end

    always @(negedge clk) begin
        int e_dig, e_ana, e_sel, e_busy, e_cen;
        if (rst_n && !finished) begin
            e_dig  = (m_st == 0) || (m_st == 3 && m_dir == 0);
            e_ana  = (m_st == 1) || (m_st == 3 && m_dir == 1);
            e_sel  = (m_st == 1) || (m_st == 2 && m_dir == 0) || (m_st == 3 && m_dir == 1);
            e_busy = (m_st >= 2);
            e_cen  = clk_req && !e_busy && (e_sel ? ana_lock : dig_lock);
            check(cur_req, "dig_en", dig_en, e_dig);
            check(cur_req, "ana_en", ana_en, e_ana);
            check(cur_req, "src_sel", src_sel, e_sel);
            check(cur_req, "busy", busy, e_busy);
            check(cur_req, "done", done, m_done);
            check(cur_req, "err", err, m_err);
            check("R10", "clk_en", clk_en, e_cen);
            check("R5", "exclusive enables", int'(dig_en && ana_en), 0);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic pulse(input logic to_ana);
        sw_req = 1'b1; sw_to_ana = to_ana;
        cyc(1);
        sw_req = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        #1;
        check("R1", "reset dig_en", dig_en, 1);
        check("R1", "reset src_sel", src_sel, 0);
        check("R1", "reset busy/err", int'(busy | err | done | ana_en), 0);

        // R10: gate follows request and lock
        cur_req = "R10";
        dig_lock = 1'b1; clk_req = 1'b1;
        cyc(2);
        check("R10", "clk_en granted", clk_en, 1);
        clk_req = 1'b0; #1;
        check("R10", "clk_en released", clk_en, 0);
        clk_req = 1'b1;

        // R6: command for the source already running
        cur_req = "R6";
        pulse(1'b0);
        check("R6", "same-target ignored busy", busy, 0);
        check("R6", "same-target ignored sel", src_sel, 0);

        // R2, R3, R4: move to analog
        cur_req = "R2";
        pulse(1'b1);
        check("R2", "release dig_en", dig_en, 0);
        check("R2", "release busy", busy, 1);
        cur_req = "R3";
        cyc(3);
        check("R3", "analog held off", ana_en, 0);
        cur_req = "R6";
        pulse(1'b0);
        check("R6", "busy cmd ignored", busy, 1);
        cur_req = "R3";
        dig_lock = 1'b0;
        cyc(1);
        check("R3", "analog enabled", ana_en, 1);
        check("R3", "analog selected", src_sel, 1);
        cur_req = "R4";
        cyc(2);
        ana_lock = 1'b1;
        cyc(1);
        check("R4", "done pulse", done, 1);
        check("R4", "not busy", busy, 0);
        cyc(1);
        check("R4", "done single", done, 0);

        // R7: back to digital
        cur_req = "R7";
        pulse(1'b0);
        cyc(2);
        ana_lock = 1'b0;
        cyc(3);
        dig_lock = 1'b1;
        cyc(2);
        check("R7", "digital running", dig_en, 1);
        check("R7", "digital selected", src_sel, 0);
        check("R7", "no error", err, 0);

        // R8: release timeout (digital never drops lock)
        cur_req = "R8";
        pulse(1'b1);
        cyc(LIM - 1);
        check("R8", "still busy before limit", busy, 1);
        cyc(1);
        check("R8", "timeout back home", dig_en, 1);
        check("R8", "timeout err", err, 1);
        check("R8", "timeout no done", done, 0);

        // R8 in acquire step, then R9 through a good switch
        pulse(1'b1);
        dig_lock = 1'b0;
        cyc(LIM + 3);
        check("R8", "acquire timeout home", int'(dig_en && !src_sel && !busy), 1);
        dig_lock = 1'b1;
        cur_req = "R9";
        pulse(1'b1);
        dig_lock = 1'b0;
        cyc(2);
        ana_lock = 1'b1;
        cyc(2);
        check("R9", "err sticky", err, 1);
        check("R9", "switch still works", src_sel, 1);

        // reset clears err
        cur_req = "R1";
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        #1;
        check("R1", "err cleared by reset", err, 0);
        cyc(3);
        finish_run();
    end

endmodule